// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block predicts the direction and destination of a branch from its address. Each lookup probes a four-way set-associative table of 512 entries. An entry holds the address tag, the destination seen when the branch was last taken, and a 4-bit record of its recent outcomes. On a hit, that record selects one of sixteen shared 2-bit saturating counters, and the counter gives the direction. On a miss, a fixed rule picks the direction from the kind of branch. A return is predicted taken. Any other branch that is not relative to the instruction pointer is predicted not taken. A relative branch is predicted taken only when its displacement points backward.

When a branch resolves, the update port reports its address, its outcome and its real destination. If the branch is already stored, its entry learns the outcome. If it is not stored, it is placed in the set. An empty way is used first; otherwise the least recently used way is replaced.

The lookup request is a valid/ready stream. A request transfers on a cycle where both `lk_valid` and `lk_ready` are high. `lk_ready` drops only when an update to the same set is presented in that cycle, so the update always wins. The requester must then hold its request until `lk_ready` returns. The response has no back-pressure: it appears for exactly one cycle, one cycle after the transfer. Updates are never refused.

Top module: `branch_target_predictor`

## Requirements
- R1: After reset, `rsp_valid` is low, every entry is empty so every lookup misses, and all sixteen direction counters hold the value 1.
- R2: A lookup that transfers in cycle t gives `rsp_valid` high in cycle t+1 only. In a cycle that follows no transfer, `rsp_valid` is low.
- R3: `lk_ready` is low exactly when `upd_valid` is high and the set index of `upd_addr` equals the set index of `lk_addr`. Otherwise it is high.
- R4: On a miss, `rsp_hit` is 0 and `rsp_target` is 0. If `lk_iprel` is 0, `rsp_taken` equals `lk_return`.
- R5: On a miss with `lk_iprel` = 1, `rsp_taken` equals `lk_backward`.
- R6: An update whose address is not stored installs an entry. A later lookup of that address hits and returns `upd_target` as `rsp_target`. The tags within one set are always distinct.
- R7: On a hit, `rsp_taken` is 1 exactly when the counter indexed by the entry's history is 2 or 3. An update that hits changes the counter indexed by the entry's history before the update. The counter goes up by one on a taken outcome and down by one on a not-taken outcome, and it saturates at 3 and at 0. Installs leave the counters unchanged.
- R8: An update that hits shifts the outcome (taken = 1) into bit 0 of the history and drops bit 3. An install sets the history to 000 followed by the outcome.
- R9: An update that hits replaces the stored destination only when the outcome is taken. A not-taken update keeps the old destination.
- R10: An install uses the lowest-numbered empty way of the set. If the set is full, it uses the least recently used way. Recency is refreshed by lookup hits, update hits and installs.
- R11: The set index is address bits [8:2] and the tag is bits [31:9]. Bits [1:0] have no effect on the lookup or on the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_addr | input | 32 | Branch address to look up |
| lk_iprel | input | 1 | Branch is relative to the instruction pointer |
| lk_return | input | 1 | Branch is a return |
| lk_backward | input | 1 | Displacement points backward |
| rsp_valid | output | 1 | Prediction present (one cycle after transfer) |
| rsp_hit | output | 1 | Address was found in the table |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_target | output | 32 | Stored destination on a hit, 0 on a miss |
| upd_valid | input | 1 | Resolved branch report present |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | 32 | Actual destination |

## Verification
Some rules are checked by assertions on every cycle. A response only ever follows a transfer, and a miss always returns a zero destination with the static direction. A set never holds two matching tags. Its recency ages always form a permutation. A direction counter moves only at the index an update addressed. The bench scenarios show the rest: that learned histories and counters steer later hits, that a full set gives up its least recently used way, and that a not-taken report leaves the stored destination alone. They also show that the update wins over a lookup to the same set, and that the low address bits are ignored. These are followed against a behavioural model over directed and random traffic.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_static_rule.sv
module btb_static_rule (
  input  logic iprel,
  input  logic is_return,
  input  logic backward,
  output logic taken
);
  always_comb begin
    if (iprel) taken = backward;
    else       taken = is_return;
  end
endmodule

// File: rtl/btb_pattern_table.sv
module btb_pattern_table #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);
  import btb_pkg::*;
  localparam int N = 1 << HIST_W;

  ctr_t ctr [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ctr[i] <= 2'd1;
    end else if (wr_en) begin
      ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
    end
  end

  assign rd_taken = ctr_says_taken(ctr[rd_idx]);

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_ctr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr[g] != $past(ctr[g])) |-> ($past(wr_en) && $past(wr_idx) == HIST_W'(g)));
  end
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_touch,
  input  logic [$clog2(SETS)-1:0] a_set,
  input  logic [$clog2(WAYS)-1:0] a_way,
  input  logic                    b_touch,
  input  logic [$clog2(SETS)-1:0] b_set,
  input  logic [$clog2(WAYS)-1:0] b_way,
  input  logic [$clog2(SETS)-1:0] q_set,
  output logic [$clog2(WAYS)-1:0] q_victim
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else begin
      if (a_touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == a_way)             age[a_set][w] <= '0;
          else if (age[a_set][w] < age[a_set][a_way]) age[a_set][w] <= age[a_set][w] + 1'b1;
        end
      end
      if (b_touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == b_way)             age[b_set][w] <= '0;
          else if (age[b_set][w] < age[b_set][b_way]) age[b_set][w] <= age[b_set][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    q_victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[q_set][w] == OLDEST) q_victim = WAY_W'(w);
  end

  logic [WAYS-1:0] present;
  always_comb begin
    present = '0;
    for (int w = 0; w < WAYS; w++) present[age[q_set][w]] = 1'b1;
  end

  assert_lru_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    &present);
  assert_touch_sets_differ_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_touch && b_touch) |-> (a_set != b_set));

  logic [IDX_W-1:0] unused_idx_ok;
  assign unused_idx_ok = '0;
endmodule

// File: rtl/branch_target_predictor.sv
module branch_target_predictor #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int HIST_W = 4,
  parameter int ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_iprel,
  input  logic              lk_return,
  input  logic              lk_backward,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_taken,
  output logic [TGT_W-1:0]  rsp_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [TGT_W-1:0]  upd_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN;

  logic              ent_vld [SETS][WAYS];
  logic [TAG_W-1:0]  ent_tag [SETS][WAYS];
  logic [TGT_W-1:0]  ent_tgt [SETS][WAYS];
  logic [HIST_W-1:0] ent_hst [SETS][WAYS];

  // address split
  logic [IDX_W-1:0] l_set, u_set;
  logic [TAG_W-1:0] l_tag, u_tag;
  assign l_set = lk_addr[ALIGN +: IDX_W];
  assign l_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign u_set = upd_addr[ALIGN +: IDX_W];
  assign u_tag = upd_addr[ADDR_W-1 -: TAG_W];

  logic unused_low_bits;
  assign unused_low_bits = ^{lk_addr[ALIGN-1:0], upd_addr[ALIGN-1:0]};

  // lookup tag match
  logic [WAYS-1:0]   l_match;
  logic              l_hit;
  logic [WAY_W-1:0]  l_way;
  logic [HIST_W-1:0] l_hist;
  logic [TGT_W-1:0]  l_tgt;
  always_comb begin
    l_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      l_match[w] = ent_vld[l_set][w] && (ent_tag[l_set][w] == l_tag);
      if (l_match[w]) l_way = WAY_W'(w);
    end
    l_hit  = |l_match;
    l_hist = ent_hst[l_set][l_way];
    l_tgt  = ent_tgt[l_set][l_way];
  end

  // update tag match and placement
  logic [WAYS-1:0]   u_match;
  logic              u_hit;
  logic [WAY_W-1:0]  u_way;
  logic              u_has_free;
  logic [WAY_W-1:0]  u_free;
  logic [WAY_W-1:0]  u_victim;
  logic [WAY_W-1:0]  u_dest;
  logic [HIST_W-1:0] u_hist;
  always_comb begin
    u_way      = '0;
    u_free     = '0;
    u_has_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      u_match[w] = ent_vld[u_set][w] && (ent_tag[u_set][w] == u_tag);
      if (u_match[w]) u_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!ent_vld[u_set][w]) begin
        u_free     = WAY_W'(w);
        u_has_free = 1'b1;
      end
    end
    u_hit  = |u_match;
    u_dest = u_hit ? u_way : (u_has_free ? u_free : u_victim);
    u_hist = ent_hst[u_set][u_way];
  end

  assign lk_ready = !(upd_valid && (u_set == l_set));

  logic lk_fire;
  assign lk_fire = lk_valid && lk_ready;

  // direction sources
  logic pat_taken, static_taken;

  btb_pattern_table #(.HIST_W(HIST_W)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (l_hist),
    .rd_taken (pat_taken),
    .wr_en    (upd_valid && u_hit),
    .wr_idx   (u_hist),
    .wr_taken (upd_taken)
  );

  btb_static_rule u_static (
    .iprel     (lk_iprel),
    .is_return (lk_return),
    .backward  (lk_backward),
    .taken     (static_taken)
  );

  btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_touch  (lk_fire && l_hit),
    .a_set    (l_set),
    .a_way    (l_way),
    .b_touch  (upd_valid),
    .b_set    (u_set),
    .b_way    (u_dest),
    .q_set    (u_set),
    .q_victim (u_victim)
  );

  // entry state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_vld[s][w] <= 1'b0;
    end else if (upd_valid && !u_hit) begin
      ent_vld[u_set][u_dest] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      if (u_hit) begin
        ent_hst[u_set][u_dest] <= {u_hist[HIST_W-2:0], upd_taken};
        if (upd_taken) ent_tgt[u_set][u_dest] <= upd_target;
      end else begin
        ent_tag[u_set][u_dest] <= u_tag;
        ent_tgt[u_set][u_dest] <= upd_target;
        ent_hst[u_set][u_dest] <= {{(HIST_W-1){1'b0}}, upd_taken};
      end
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
    end else begin
      rsp_valid <= lk_fire;
      if (lk_fire) begin
        rsp_hit    <= l_hit;
        rsp_taken  <= l_hit ? pat_taken : static_taken;
        rsp_target <= l_hit ? l_tgt : '0;
      end
    end
  end

  assert_unique_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(l_match));
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid && lk_ready));
  assert_miss_zero_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_target == '0));
  assert_miss_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !$past(lk_iprel)) |-> (rsp_taken == $past(lk_return)));
  assert_miss_rel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && $past(lk_iprel)) |-> (rsp_taken == $past(lk_backward)));
endmodule

// File: tb/branch_target_predictor_test.sv
`timescale 1ns/1ps
module branch_target_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_iprel = 1'b0, lk_return = 1'b0, lk_backward = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_ready, rsp_valid, rsp_hit, rsp_taken;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_addr = '0, upd_target = '0;

  always #2.5 clk = ~clk;

  branch_target_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_iprel(lk_iprel), .lk_return(lk_return), .lk_backward(lk_backward),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_target(rsp_target),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R6";

  // behavioural model
  bit          m_vld [128][4];
  int unsigned m_tag [128][4];
  logic [31:0] m_tgt [128][4];
  int          m_hst [128][4];
  int          m_pat [16];
  int          m_order [128][$];   // front = most recent

  bit          e_valid, e_hit, e_taken;
  logic [31:0] e_tgt;
  bit          e_iprel;

  function automatic int set_of(logic [31:0] a); return int'(a[8:2]); endfunction
  function automatic int unsigned tag_of(logic [31:0] a); return int'(a[31:9]); endfunction
  function automatic logic [31:0] mk(int unsigned tag, int s, int low);
    return {tag[22:0], s[6:0], low[1:0]};
  endfunction

  function automatic int find(int s, int unsigned t);
    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic touch(int s, int w);
    for (int i = 0; i < m_order[s].size(); i++)
      if (m_order[s][i] == w) begin m_order[s].delete(i); break; end
    m_order[s].push_front(w);
  endtask

  task automatic model_reset();
    for (int s = 0; s < 128; s++) begin
      m_order[s].delete();
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_order[s].push_back(w); end
    end
    for (int i = 0; i < 16; i++) m_pat[i] = 1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit lv, logic [31:0] la, bit ip, bit rt, bit bk,
                      bit uv, logic [31:0] ua, bit ut, logic [31:0] utg);
    bit rdy;
    int ls, lw, us, uw;
    lk_valid = lv; lk_addr = la; lk_iprel = ip; lk_return = rt; lk_backward = bk;
    upd_valid = uv; upd_addr = ua; upd_taken = ut; upd_target = utg;
    #1;
    ls = set_of(la); us = set_of(ua);
    rdy = !(uv && us == ls);
    if (lv) check("R3", {31'b0, lk_ready}, {31'b0, rdy});
    // lookup on pre-update state
    e_valid = lv && rdy;
    e_iprel = ip;
    lw = find(ls, tag_of(la));
    e_hit = (lw >= 0);
    if (e_hit) begin
      e_taken = m_pat[m_hst[ls][lw]] >= 2;
      e_tgt   = m_tgt[ls][lw];
    end else begin
      e_taken = ip ? bk : rt;
      e_tgt   = '0;
    end
    // update
    if (uv) begin
      uw = find(us, tag_of(ua));
      if (uw >= 0) begin
        int h = m_hst[us][uw];
        m_pat[h] = ut ? ((m_pat[h] < 3) ? m_pat[h] + 1 : 3) : ((m_pat[h] > 0) ? m_pat[h] - 1 : 0);
        m_hst[us][uw] = ((h << 1) | int'(ut)) & 15;
        if (ut) m_tgt[us][uw] = utg;
      end else begin
        uw = -1;
        for (int w = 0; w < 4; w++) if (!m_vld[us][w] && uw < 0) uw = w;
        if (uw < 0) uw = m_order[us][$];
        m_vld[us][uw] = 1; m_tag[us][uw] = tag_of(ua);
        m_tgt[us][uw] = utg; m_hst[us][uw] = int'(ut);
      end
      touch(us, uw);
    end
    if (e_valid && e_hit) touch(ls, lw);
    @(posedge clk);
    @(negedge clk);
    check("R2", {31'b0, rsp_valid}, {31'b0, e_valid});
    if (e_valid) begin
      check(e_hit ? cur_req : (e_iprel ? "R5" : "R4"), {31'b0, rsp_hit}, {31'b0, e_hit});
      check(e_hit ? "R7" : (e_iprel ? "R5" : "R4"), {31'b0, rsp_taken}, {31'b0, e_taken});
      check(e_hit ? "R9" : "R4", rsp_target, e_tgt);
    end
  endtask

  task automatic look(logic [31:0] a, bit ip = 0, bit rt = 0, bit bk = 0);
    step(1, a, ip, rt, bk, 0, 32'h0, 0, 32'h0);
  endtask
  task automatic upd(logic [31:0] a, bit t, logic [31:0] tg);
    step(0, 32'h0, 0, 0, 0, 1, a, t, tg);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing valid out of reset
    check("R1", {31'b0, rsp_valid}, 32'd0);

    // R1, R4, R5: every combination misses with the static rule
    for (int k = 0; k < 8; k++) look(mk(32'h100 + k, k, 0), k[0], k[1], k[2]);

    // R6: install then hit
    cur_req = "R6";
    a = mk(32'h55, 10, 0);
    upd(a, 1, 32'hCAFE_0000);
    look(a);
    // R7, R8: train history and counters
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin upd(a, 1, 32'hCAFE_0000 + k); look(a); end
    for (int k = 0; k < 3; k++) begin upd(a, 0, 32'h0); look(a); end
    // R9: not-taken keeps destination
    upd(a, 0, 32'hDEAD_BEEF);
    look(a);

    // R11: low bits ignored on lookup and update
    cur_req = "R11";
    look(a | 32'h3);
    upd(a | 32'h1, 1, 32'h1234_5678);
    look(a | 32'h2);

    // R3: update to same set stalls, different set proceeds
    step(1, a, 0, 0, 0, 1, mk(32'h77, 10, 0), 1, 32'h42);
    step(1, a, 0, 0, 0, 1, mk(32'h77, 11, 0), 1, 32'h43);
    step(0, a, 0, 0, 0, 0, 32'h0, 0, 32'h0);

    // R10: fill set 20, refresh some ways, then force evictions
    cur_req = "R10";
    for (int k = 0; k < 4; k++) upd(mk(32'h200 + k, 20, 0), 1, 32'hA000 + k);
    look(mk(32'h200, 20, 0));
    look(mk(32'h201, 20, 0));
    upd(mk(32'h2FF, 20, 0), 1, 32'hBBBB);
    for (int k = 0; k < 4; k++) look(mk(32'h200 + k, 20, 0));
    look(mk(32'h2FF, 20, 0));
    upd(mk(32'h2FE, 20, 0), 0, 32'hCCCC);
    for (int k = 0; k < 4; k++) look(mk(32'h200 + k, 20, 0));

    // mixed random traffic over a few crowded sets
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom;
      step(r[0], mk(r[4:2], 3 + r[6:5] % 3, r[8:7]), r[9], r[10], r[11],
           r[12] | r[13], mk(r[16:14], 3 + r[18:17] % 3, r[20:19]), r[21], {r[31:22], r[11:0], 10'h0});
    end
    step(0, 32'h0, 0, 0, 0, 0, 32'h0, 0, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule